// File: doc/BRIEF.md
# Bimodal Direction Predictor with Shared Confidence Bits

This block is the base direction table of a branch predictor. It is indexed by a branch index that has already been formed outside the block. Each entry holds one direction bit. A single confidence (hysteresis) bit is shared by a group of 2^R neighbouring entries. Sharing the confidence bit cuts storage compared with a full two-bit counter per entry, at the cost of some interference between the entries of a group.

A lookup port returns the stored direction bit for any index in the same cycle, and the confidence bit has no part in that result. An update port takes a resolved outcome. It joins the entry's direction bit and its group's confidence bit into a two-bit saturating counter, steps the counter toward the outcome, and writes both bits back on the clock edge. The table has 2^L entries and 2^(L-R) confidence bits, with 0 <= R <= L. With R = 0 every entry has its own confidence bit, and the block is a plain two-bit counter table.

Top module: `bimodal_hyst_pred`

## Requirements
- R1: After a synchronous reset every direction bit is 0 (not taken), so every lookup returns 0.
- R2: After reset every confidence bit is 1, so one taken update to any entry makes its lookup return 1.
- R3: `lookup_taken` is the direction bit of the entry at `lookup_idx`, available combinationally in the same cycle.
- R4: An update with `upd_taken`=1 forms the value {direction, confidence}, with direction as bit 1 and confidence as bit 0, and increments it unless it is already 3.
- R5: An update with `upd_taken`=0 decrements that value unless it is already 0.
- R6: The direction bit is addressed by `upd_idx`, and the confidence bit by `upd_idx >> R`. An update to one entry therefore changes the confidence seen by the other entries of its group.
- R7: While `upd_valid` is 0 no stored bit changes, whatever `upd_idx` and `upd_taken` carry.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the value from before the update.
- R9: An update writes only the addressed direction bit and its group's confidence bit. Every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_idx | input | L | Index read by the lookup port |
| lookup_taken | output | 1 | Predicted direction for `lookup_idx` (1 = taken) |
| upd_valid | input | 1 | Apply an update on this clock edge |
| upd_idx | input | L | Index of the entry to train |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The assertions assume that `upd_idx` is a known value whenever `upd_valid` is high, and that at most one update arrives per cycle. The port width enforces the second point. The bench drives every input from a known state after reset and never leaves the update index undefined. The bench runs a 16-entry table with groups of four. After every update it sweeps all indices through the lookup port and compares each one with its own model of the two arrays. The stimulus is chosen to reach both saturation ends, idle cycles that carry toggling update fields, and updates to neighbours that share a confidence bit.

// File: rtl/bimodal_pkg.sv
package bimodal_pkg;

    // Two-bit confidence counter: direction bit is the high bit.
    typedef struct packed {
        logic dir;
        logic conf;
    } bim_ctr_t;

    localparam logic [1:0] CTR_TOP = 2'd3;
    localparam logic [1:0] CTR_BOT = 2'd0;

    function automatic bim_ctr_t bim_step(input bim_ctr_t cur, input logic taken);
        logic [1:0] v;
        v = cur;
        if (taken) begin
            if (v != CTR_TOP) v = v + 2'd1;
        end else begin
            if (v != CTR_BOT) v = v - 2'd1;
        end
        return bim_ctr_t'(v);
    endfunction

endpackage

// File: rtl/bim_bit_store.sv
module bim_bit_store #(
    parameter int IW      = 4,
    parameter int DEPTH   = 16,
    parameter int NRD     = 1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NRD-1:0][IW-1:0]  rd_idx,
    output logic [NRD-1:0]          rd_bit,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic                    wr_bit
);

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= {DEPTH{RST_VAL}};
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_bit;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_bit[g] = bits_q[rd_idx[g]];
    end

    // R7: no write enable, no change
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bits_q));

    // R9: a write touches at most one bit
    p_single_bit_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($countones(bits_q ^ $past(bits_q)) <= 1));

endmodule

// File: rtl/bim_ctr_step.sv
module bim_ctr_step
    import bimodal_pkg::*;
(
    input  bim_ctr_t cur_ctr,
    input  logic     taken,
    output bim_ctr_t nxt_ctr
);

    always_comb begin
        nxt_ctr = bim_step(cur_ctr, taken);
    end

endmodule

// File: rtl/bimodal_hyst_pred.sv
module bimodal_hyst_pred
    import bimodal_pkg::*;
#(
    parameter int L = 10,
    parameter int R = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [L-1:0] lookup_idx,
    output logic         lookup_taken,
    input  logic         upd_valid,
    input  logic [L-1:0] upd_idx,
    input  logic         upd_taken
);

    localparam int DIR_DEPTH  = 1 << L;
    localparam int CONF_DEPTH = 1 << (L - R);
    localparam int CIW        = (L - R > 0) ? (L - R) : 1;

    logic [1:0][L-1:0] dir_rd_idx;
    logic [1:0]        dir_rd_bit;
    logic [CIW-1:0]    conf_idx;
    logic              conf_rd_bit;
    bim_ctr_t          cur_ctr;
    bim_ctr_t          nxt_ctr;

    assign conf_idx      = CIW'(upd_idx >> R);
    assign dir_rd_idx[0] = lookup_idx;
    assign dir_rd_idx[1] = upd_idx;
    assign lookup_taken  = dir_rd_bit[0];
    assign cur_ctr       = '{dir: dir_rd_bit[1], conf: conf_rd_bit};

    bim_bit_store #(
        .IW(L), .DEPTH(DIR_DEPTH), .NRD(2), .RST_VAL(1'b0)
    ) u_dir (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (dir_rd_idx),
        .rd_bit (dir_rd_bit),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_bit (nxt_ctr.dir)
    );

    bim_bit_store #(
        .IW(CIW), .DEPTH(CONF_DEPTH), .NRD(1), .RST_VAL(1'b1)
    ) u_conf (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (conf_idx),
        .rd_bit (conf_rd_bit),
        .wr_en  (upd_valid),
        .wr_idx (conf_idx),
        .wr_bit (nxt_ctr.conf)
    );

    bim_ctr_step u_step (
        .cur_ctr (cur_ctr),
        .taken   (upd_taken),
        .nxt_ctr (nxt_ctr)
    );

    // R1: the cycle after reset every lookup reads not-taken
    p_reset_dir_r1: assert property (@(posedge clk)
        rst |=> !lookup_taken);

    // R4: taken at the top stays at the top
    p_sat_top_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && cur_ctr == CTR_TOP)
        |=> (u_dir.bits_q[$past(upd_idx)] && u_conf.bits_q[$past(conf_idx)]));

    // R5: not-taken at the bottom stays at the bottom
    p_sat_bot_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && cur_ctr == CTR_BOT)
        |=> (!u_dir.bits_q[$past(upd_idx)] && !u_conf.bits_q[$past(conf_idx)]));

    // R4: below the top, a taken update raises the counter by one
    p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && cur_ctr != CTR_TOP)
        |=> ({u_dir.bits_q[$past(upd_idx)], u_conf.bits_q[$past(conf_idx)]}
             == $past(cur_ctr) + 2'd1));

endmodule

// File: tb/bimodal_hyst_pred_bench.sv
`timescale 1ns/1ps
module bimodal_hyst_pred_bench;

    localparam int L = 4;
    localparam int R = 2;
    localparam int N = 1 << L;
    localparam int G = 1 << (L - R);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [L-1:0] lookup_idx = '0;
    logic         lookup_taken;
    logic         upd_valid = 1'b0;
    logic [L-1:0] upd_idx = '0;
    logic         upd_taken = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_dir  [N];
    bit m_conf [G];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    bimodal_hyst_pred #(.L(L), .R(R)) u_bimodal_hyst_pred (
        .clk(clk), .rst(rst), .lookup_idx(lookup_idx), .lookup_taken(lookup_taken),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < N; i++) begin
            lookup_idx = L'(i);
            #1;
            chk(req, lookup_taken, m_dir[i]);
        end
    endtask

    task automatic model_step(input int idx, input bit t);
        int v;
        v = (m_dir[idx] ? 2 : 0) + (m_conf[idx >> R] ? 1 : 0);
        if (t && v < 3) v++;
        else if (!t && v > 0) v--;
        m_dir[idx] = v[1];
        m_conf[idx >> R] = v[0];
    endtask

    // Drive at the falling edge; R8 check before the rising edge.
    task automatic upd(input int idx, input bit t);
        @(negedge clk);
        upd_valid = 1'b1; upd_idx = L'(idx); upd_taken = t;
        lookup_idx = L'(idx);
        #1;
        chk("R8", lookup_taken, m_dir[idx]);
        @(posedge clk);
        model_step(idx, t);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_dir[i] = 1'b0;
        for (int i = 0; i < G; i++) m_conf[i] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1");

        // R2: one taken update raises 1 -> 2
        upd(5, 1'b1);
        lookup_idx = 4'd5; #1; chk("R2", lookup_taken, 1'b1);
        sweep("R3");
        // R6: neighbour 4 now sees confidence 0, so taken gives 1, not 2
        upd(4, 1'b1);
        lookup_idx = 4'd4; #1; chk("R6", lookup_taken, 1'b0);
        lookup_idx = 4'd5; #1; chk("R9", lookup_taken, 1'b1);
        sweep("R6");

        // R4: saturate high, one not-taken leaves direction set
        for (int k = 0; k < 5; k++) upd(9, 1'b1);
        upd(9, 1'b0);
        lookup_idx = 4'd9; #1; chk("R4", lookup_taken, 1'b1);
        // R5: saturate low, one taken leaves direction clear
        for (int k = 0; k < 6; k++) upd(9, 1'b0);
        upd(9, 1'b1);
        lookup_idx = 4'd9; #1; chk("R5", lookup_taken, 1'b0);
        sweep("R9");

        // R7: idle cycles with toggling update fields
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            upd_idx = L'(k); upd_taken = k[0];
        end
        @(negedge clk);
        sweep("R7");

        // Pseudo-random training with full sweeps
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:6] == 2'b00) begin
                @(negedge clk);
                upd_idx = lfsr[3:0]; upd_taken = lfsr[4];
                @(negedge clk);
                sweep("R7");
            end else begin
                upd(int'(lfsr[3:0]), lfsr[4]);
                sweep("R9");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule